// File: doc/BRIEF.md
# External Interrupt Input Unit

This block sits between six external interrupt pins and a downstream interrupt controller. Every pin first passes through a two-stage synchronizer. A per-pin trigger mode then looks for a condition on the synchronized signal: a rising edge, a falling edge, either edge, a high level or a low level. When the condition is seen, the pin's pending flag is set. A pending flag that is also enabled drives a registered request line toward the controller.

Software reaches the block through a simple 32-bit register port: a write strobe, a byte offset and write data, with read data returned combinationally for the offset presented. There are three registers: a packed trigger-mode register with a 4-bit field per pin, a pending register and an enable register. In edge modes a pending flag latches until software clears it. In level modes the flag follows the synchronized pin level.

Top module: `ext_irq_front`

## Requirements
- R1: After reset the mode, pending and enable registers all read zero and every request output is low.
- R2: The mode register sits at offset 0x0, and pin i uses bits [4i+3:4i]. It is read/write on bits 23:0, and its upper bits read zero. The pending register sits at offset 0x4 and the enable register at offset 0xC, each on bits 5:0 with upper bits reading zero. Every other offset reads zero and ignores writes.
- R3: A pin change is seen only after two synchronizer flops. In rising-edge mode, a pin that rises before clock edge 1 shows pending after edge 3, and not yet after edge 2.
- R4: Mode code 1 (rising edge) sets pending on a low-to-high transition. The flag stays set after the pin returns low.
- R5: Mode code 2 (falling edge) sets pending on a high-to-low transition and ignores a low-to-high transition.
- R6: Mode code 3 (both edges) sets pending on either transition.
- R7: In mode code 5 (high level), pending follows the synchronized pin: set while the pin is high, cleared once it has been low through the synchronizer.
- R8: In mode code 6 (low level), pending is set while the synchronized pin is low and cleared once it is high.
- R9: Codes 0, 4 and 7 to 15 disable the pin. Its pending flag is never set by pin activity.
- R10: A write to offset 0x4 clears each edge-latched pending bit written as 0 and leaves each bit written as 1 unchanged. The clear is visible on the next read.
- R11: Request i is high exactly when pending bit i and enable bit i were both set in the previous cycle. A pending pin with its enable bit at 0 raises no request.
- R12: In level modes a software clear has no lasting effect: while the level is active, pending reads 1 again right after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 6 | Asynchronous external interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the presented offset |
| irq_req | output | 6 | Registered request lines to the interrupt controller |

## Verification
The bench builds the block with its default parameters: six pins, 4-bit mode fields, a 32-bit data port and two synchronizer stages. With these values the top field (pin 5, bits 23:20) and the zero upper bits of every register are within reach of a check. Because the synchronizer depth is the default, exact three-edge detection latencies and one further edge of request latency can be checked, and each trigger code gets its own pin, so the per-pin field slicing is checked as well.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
    localparam int MODE_BITS = 4;

    localparam logic [MODE_BITS-1:0] TRG_OFF  = 4'd0;
    localparam logic [MODE_BITS-1:0] TRG_RISE = 4'd1;
    localparam logic [MODE_BITS-1:0] TRG_FALL = 4'd2;
    localparam logic [MODE_BITS-1:0] TRG_BOTH = 4'd3;
    localparam logic [MODE_BITS-1:0] TRG_HIGH = 4'd5;
    localparam logic [MODE_BITS-1:0] TRG_LOW  = 4'd6;

    localparam int OFS_MODE = 'h0;
    localparam int OFS_PEND = 'h4;
    localparam int OFS_ENAB = 'hC;

    function automatic logic is_edge_mode(input logic [MODE_BITS-1:0] m);
        return (m == TRG_RISE) || (m == TRG_FALL) || (m == TRG_BOTH);
    endfunction

    function automatic logic is_level_mode(input logic [MODE_BITS-1:0] m);
        return (m == TRG_HIGH) || (m == TRG_LOW);
    endfunction
endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/eiu_detect.sv
module eiu_detect
    import eiu_pkg::*;
(
    input  logic [MODE_BITS-1:0] mode,
    input  logic                 cur,
    input  logic                 prev,
    output logic                 hit,
    output logic                 level
);
    always_comb begin
        hit   = 1'b0;
        level = 1'b0;
        case (mode)
            TRG_RISE: hit = cur & ~prev;
            TRG_FALL: hit = ~cur & prev;
            TRG_BOTH: hit = cur ^ prev;
            TRG_HIGH: begin hit = cur;  level = 1'b1; end
            TRG_LOW:  begin hit = ~cur; level = 1'b1; end
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front
    import eiu_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] ext_pin,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_PINS-1:0] irq_req
);
    localparam int MODE_W = NUM_PINS * MODE_BITS;
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(OFS_ENAB);

    typedef struct packed {
        logic [MODE_W-1:0]   mode;
        logic [NUM_PINS-1:0] pend;
        logic [NUM_PINS-1:0] enab;
        logic [NUM_PINS-1:0] prev;
        logic [NUM_PINS-1:0] req;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_PINS-1:0] pin_s, hit, lvl;
    logic                wr_mode, wr_pend, wr_enab;
    logic [NUM_PINS-1:0] clr_mask;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:MODE_W];

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        eiu_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (ext_pin[i]),
            .q    (pin_s[i])
        );
        eiu_detect u_det (
            .mode (st_q.mode[i*MODE_BITS +: MODE_BITS]),
            .cur  (pin_s[i]),
            .prev (st_q.prev[i]),
            .hit  (hit[i]),
            .level(lvl[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        wr_mode  = reg_wr && (reg_addr == A_MODE);
        wr_pend  = reg_wr && (reg_addr == A_PEND);
        wr_enab  = reg_wr && (reg_addr == A_ENAB);
        clr_mask = wr_pend ? ~reg_wdata[NUM_PINS-1:0] : '0;

        st_d.prev = pin_s;
        if (wr_mode) st_d.mode = reg_wdata[MODE_W-1:0];
        if (wr_enab) st_d.enab = reg_wdata[NUM_PINS-1:0];

        for (int i = 0; i < NUM_PINS; i++) begin
            if (lvl[i]) st_d.pend[i] = hit[i];
            else        st_d.pend[i] = (st_q.pend[i] & ~clr_mask[i]) | hit[i];
        end

        st_d.req = st_q.pend & st_q.enab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MODE:  reg_rdata = DATA_W'(st_q.mode);
            A_PEND:  reg_rdata = DATA_W'(st_q.pend);
            A_ENAB:  reg_rdata = DATA_W'(st_q.enab);
            default: reg_rdata = '0;
        endcase
    end

    assign irq_req = st_q.req;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        logic [MODE_BITS-1:0] m;
        assign m = st_q.mode[i*MODE_BITS +: MODE_BITS];

        AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_edge_mode(m) && !is_level_mode(m) && !st_q.pend[i]) |=> !st_q.pend[i]); // R9

        AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (is_edge_mode(m) && st_q.pend[i] && !(wr_pend && !reg_wdata[i])) |=> st_q.pend[i]); // R10

        AST_HIGH_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            (m == TRG_HIGH && pin_s[i]) |=> st_q.pend[i]); // R7

        AST_LOW_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            (m == TRG_LOW && !pin_s[i]) |=> st_q.pend[i]); // R8

        AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[i] |-> $past(st_q.enab[i])); // R11
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != A_MODE && reg_addr != A_PEND && reg_addr != A_ENAB) |-> reg_rdata == '0); // R2
endmodule

// File: tb/ext_irq_front_test.sv
`timescale 1ns/1ps
module ext_irq_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ext_pin = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  irq_req;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ext_irq_front uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic t_reset();
        rd(4'h0, 32'h0, "R1 mode");
        rd(4'h4, 32'h0, "R1 pend");
        rd(4'hC, 32'h0, "R1 enab");
        check("R1 irq_req", {26'h0, irq_req}, 32'h0);
    endtask

    task automatic t_regmap();
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, 32'h00FF_FFFF, "R2 mode width");
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, 32'h0000_003F, "R2 enab width");
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, 32'h0, "R2 unmapped");
        wr(4'h0, 32'h0000_A5C3);
        rd(4'h0, 32'h0000_A5C3, "R2 mode value");
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h0);
        rd(4'hC, 32'h0, "R2 enab clear");
        rd(4'h4, 32'h0, "R2 pend quiet");
    endtask

    task automatic t_rise();
        wr(4'h0, 32'h1);
        cyc(3);
        ext_pin[0] = 1'b1;
        cyc(2);
        rd(4'h4, 32'h0, "R3 not after two edges");
        cyc(1);
        rd(4'h4, 32'h1, "R3 after three edges");
        ext_pin[0] = 1'b0;
        cyc(4);
        rd(4'h4, 32'h1, "R4 latched after low");
        wr(4'h4, 32'h3E);
        rd(4'h4, 32'h0, "R10 clear bit0");
        cyc(3);
        rd(4'h4, 32'h0, "R4 fall ignored");
    endtask

    task automatic t_fall();
        wr(4'h0, 32'h20);
        ext_pin[1] = 1'b1;
        cyc(4);
        rd(4'h4, 32'h0, "R5 rise ignored");
        ext_pin[1] = 1'b0;
        cyc(4);
        rd(4'h4, 32'h2, "R5 fall sets");
        wr(4'h4, 32'h3D);
        rd(4'h4, 32'h0, "R10 clear bit1");
    endtask

    task automatic t_both();
        wr(4'h0, 32'h300);
        ext_pin[2] = 1'b1;
        cyc(4);
        rd(4'h4, 32'h4, "R6 rise sets");
        wr(4'h4, 32'h3F);
        rd(4'h4, 32'h4, "R10 write one keeps");
        wr(4'h4, 32'h3B);
        rd(4'h4, 32'h0, "R10 clear bit2");
        ext_pin[2] = 1'b0;
        cyc(4);
        rd(4'h4, 32'h4, "R6 fall sets");
        wr(4'h4, 32'h0);
        rd(4'h4, 32'h0, "R10 clear all");
    endtask

    task automatic t_high();
        wr(4'h0, 32'h5000);
        ext_pin[3] = 1'b1;
        cyc(4);
        rd(4'h4, 32'h8, "R7 high sets");
        wr(4'h4, 32'h37);
        rd(4'h4, 32'h8, "R12 clear ignored");
        ext_pin[3] = 1'b0;
        cyc(4);
        rd(4'h4, 32'h0, "R7 low clears");
    endtask

    task automatic t_low();
        wr(4'h0, 32'h6_0000);
        cyc(1);
        rd(4'h4, 32'h10, "R8 low sets");
        ext_pin[4] = 1'b1;
        cyc(4);
        rd(4'h4, 32'h0, "R8 high clears");
        ext_pin[4] = 1'b0;
        cyc(4);
        rd(4'h4, 32'h10, "R8 low again");
        ext_pin[4] = 1'b1;
        cyc(4);
        rd(4'h4, 32'h0, "R8 released");
    endtask

    task automatic t_off();
        wr(4'h0, 32'h40_0000);
        ext_pin[5] = 1'b1; cyc(4); ext_pin[5] = 1'b0; cyc(4);
        rd(4'h4, 32'h0, "R9 code4");
        wr(4'h0, 32'hF0_0000);
        ext_pin[5] = 1'b1; cyc(4);
        rd(4'h4, 32'h0, "R9 code15");
        wr(4'h0, 32'h0);
        ext_pin[5] = 1'b0; cyc(4);
        rd(4'h4, 32'h0, "R9 code0");
    endtask

    task automatic t_req();
        wr(4'h0, 32'h1);
        ext_pin[0] = 1'b1;
        cyc(5);
        rd(4'h4, 32'h1, "R11 pending");
        check("R11 no enable no req", {26'h0, irq_req}, 32'h0);
        wr(4'hC, 32'h1);
        check("R11 req one edge later", {26'h0, irq_req}, 32'h0);
        cyc(1);
        check("R11 req high", {26'h0, irq_req}, 32'h1);
        wr(4'h4, 32'h0);
        check("R11 req held one edge", {26'h0, irq_req}, 32'h1);
        cyc(1);
        check("R11 req drops", {26'h0, irq_req}, 32'h0);
        ext_pin[0] = 1'b0;
        wr(4'hC, 32'h0);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_regmap();
        t_rise();
        t_fall();
        t_both();
        t_high();
        t_low();
        t_off();
        t_req();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule